// File: doc/BRIEF.md
# Oversampled serial receiver with per-entry error queue

The block turns an asynchronous serial input line into bytes. The line passes through a two-stage synchroniser. It is then sampled sixteen times per bit, at a sample rate set by a clock divider. A framing state machine finds the start bit, collects 5 to 8 data bits least significant bit first, and checks an optional parity bit and one or two stop bits. Each finished character is stored in a queue as a pair: the data byte and a four-bit error word of its own. The line format comes from static configuration inputs.

The host sees the entry at the head of the queue all the time, as `head_err` and `head_data`. It reads the error word first and then pulses `pop_data` to drop the entry. The queue reports its fill level as a 4-bit count plus a separate full flag. Three sticky interrupt causes feed one `irq` output: fill level reached, receive error, and receive timeout. Each cause is cleared by writing a one to it.

The framer has six states. IDLE goes to START on a low line. START goes back to IDLE if the line is high again at mid-bit (a rejected glitch), or on to DATA if it is still low. DATA goes to PARITY after the last data bit when parity is on, and straight to STOP when it is off. PARITY goes to STOP. STOP goes back to STOP for a second stop bit. After the last stop bit it goes to IDLE if that bit was high, or to LINE_WAIT if it was low. LINE_WAIT goes to IDLE once the line is high. A flush or a disable sends any state to IDLE.

Top module: `uart_rx_tagged`

## Requirements
- R1: `cfg_data_bits` selects the data width as the code plus 5 (code 0 gives 5 bits, code 3 gives 8). Data bits arrive least significant bit first, and unused upper bits of `head_data` read 0.
- R2: `cfg_parity` selects the parity mode: 0 none, 1 even, 2 odd, 3 forced 1, 4 forced 0. A parity bit that does not match the mode sets error bit 1 of the entry.
- R3: `cfg_two_stop` selects the number of stop bits as the value plus 1. Any stop bit sampled low sets error bit 2. Each frame stores exactly one entry.
- R4: A frame in which every bit is 0, the parity and stop bits included, is a break. It sets error bits 3 and 2, clears bit 1, and stores data 0. The receiver then waits for the line to go high before it can see a new start bit.
- R5: `head_err` and `head_data` show the oldest entry without removing it. A `pop_data` pulse removes that entry. A pop while the queue is empty has no effect.
- R6: A frame that completes while the queue holds 16 entries is discarded, and error bit 0 (overrun) is set on the entry at the head of the queue.
- R7: `fifo_count` is the fill level modulo 16, and `fifo_full` is 1 only when 16 entries are held. A full queue therefore reads count 0 with full 1.
- R8: `irq_status` bit 0 is set in every cycle in which the fill level is at or above `cfg_trig_lvl` (0 counts as 1). Bit 1 is set when a stored frame has any error or an overrun occurs. Writing 1 on `irq_clr` clears a bit, and a bit that is set again in the same cycle stays pending.
- R9: `irq_status` bit 2 (timeout) is set after 4 character times of sample ticks in which the framer is idle and either the queue is not empty or a frame has completed since the last timeout. It can therefore fire with the queue empty. A pop, a frame, or line activity restarts the wait.
- R10: A `fifo_flush` pulse, or a low `cfg_rx_en`, empties the queue and abandons any frame in progress.
- R11: A start bit is accepted only if the line is still low at mid-bit. A low pulse shorter than half a bit stores nothing.
- R12: `irq` is high exactly when any `irq_status` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| cfg_data_bits | input | 2 | Data width code (bits = code + 5) |
| cfg_parity | input | 3 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_rx_en | input | 1 | Receiver enable; low flushes |
| cfg_trig_lvl | input | 5 | Fill level for interrupt bit 0 |
| fifo_flush | input | 1 | Pulse: empty queue, restart framer |
| pop_data | input | 1 | Pulse: remove head entry |
| head_data | output | 8 | Data byte of head entry |
| head_err | output | 4 | Error word of head entry: {break, frame, parity, overrun} |
| fifo_count | output | 4 | Fill level modulo 16 |
| fifo_full | output | 1 | Queue holds 16 entries |
| irq_clr | input | 3 | Write-one-to-clear for interrupt status |
| irq_status | output | 3 | {timeout, error, level} |
| irq | output | 1 | OR of status bits |

## Verification
The bench builds the block with a divider of 1, so one bit lasts 16 clocks. With that setting, a 17-frame overrun run and the 4-character timeout window both fit in a few thousand cycles. The queue depth stays at 16, which puts the wrap of the count to 0 under the full flag within reach. The oversampling ratio also stays at 16, so the mid-bit glitch rejection and the centre sampling run at their normal positions.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_LINE_WAIT
    } rx_state_e;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_EVEN  = 3'd1;
    localparam logic [2:0] PAR_ODD   = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;

    localparam int ERR_OVR = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 2;
    localparam int ERR_BRK = 3;

    localparam int IRQ_LVL  = 0;
    localparam int IRQ_ERR  = 1;
    localparam int IRQ_TOUT = 2;

    typedef logic [3:0] rx_err_t;
endpackage

// File: rtl/rxq_tick.sv
module rxq_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(DIV);
            logic [DW-1:0] div_cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    div_cnt <= '0;
                else if (div_cnt == DW'(DIV - 1))
                    div_cnt <= '0;
                else
                    div_cnt <= div_cnt + 1'b1;
            end
            assign tick = (div_cnt == DW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/rxq_deframer.sv
module rxq_deframer
    import rxq_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] cfg_bits,
    input  logic [2:0] cfg_par,
    input  logic       cfg_two_stop,
    output logic       done,
    output logic [7:0] done_data,
    output rx_err_t    done_err,
    output logic       busy
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_e state, nxt;
    logic [CW-1:0] smp_cnt;
    logic [2:0]    bit_idx;
    logic          stop_idx;
    logic [7:0]    shreg;
    logic          par_bad, stop_bad, any_one;
    logic [2:0]    last_bit;
    logic          at_mid, at_last;

    assign last_bit = {1'b0, cfg_bits} + 3'd4;
    assign at_mid   = tick && (smp_cnt == MID);
    assign at_last  = tick && (smp_cnt == LAST);
    assign busy     = (state != RX_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (clear) begin
            nxt = RX_IDLE;
        end else begin
            unique case (state)
                RX_IDLE:      if (!rx) nxt = RX_START;
                RX_START:     if (at_mid) nxt = rx ? RX_IDLE : RX_DATA;
                RX_DATA:      if (at_last && bit_idx == last_bit)
                                  nxt = (cfg_par != PAR_NONE) ? RX_PARITY : RX_STOP;
                RX_PARITY:    if (at_last) nxt = RX_STOP;
                RX_STOP:      if (at_last && stop_idx == cfg_two_stop)
                                  nxt = rx ? RX_IDLE : RX_LINE_WAIT;
                RX_LINE_WAIT: if (rx) nxt = RX_IDLE;
                default:      nxt = RX_IDLE;
            endcase
        end
    end

    function automatic logic parity_wrong(input logic [2:0] mode,
                                          input logic [7:0] d, input logic p);
        logic odd_ones;
        odd_ones = ^d;
        unique case (mode)
            PAR_EVEN:  parity_wrong = odd_ones ^ p;
            PAR_ODD:   parity_wrong = ~(odd_ones ^ p);
            PAR_MARK:  parity_wrong = ~p;
            PAR_SPACE: parity_wrong = p;
            default:   parity_wrong = 1'b0;
        endcase
    endfunction

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_cnt   <= '0;
            bit_idx   <= '0;
            stop_idx  <= 1'b0;
            shreg     <= '0;
            par_bad   <= 1'b0;
            stop_bad  <= 1'b0;
            any_one   <= 1'b0;
            done      <= 1'b0;
            done_data <= '0;
            done_err  <= '0;
        end else begin
            done <= 1'b0;
            if (clear || state == RX_IDLE || state == RX_LINE_WAIT) begin
                smp_cnt  <= '0;
                bit_idx  <= '0;
                stop_idx <= 1'b0;
                shreg    <= '0;
                par_bad  <= 1'b0;
                stop_bad <= 1'b0;
                any_one  <= 1'b0;
            end else if (tick) begin
                unique case (state)
                    RX_START: smp_cnt <= at_mid ? '0 : smp_cnt + 1'b1;
                    RX_DATA: begin
                        if (at_last) begin
                            shreg[bit_idx] <= rx;
                            any_one        <= any_one | rx;
                            bit_idx        <= bit_idx + 1'b1;
                            smp_cnt        <= '0;
                        end else begin
                            smp_cnt <= smp_cnt + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (at_last) begin
                            par_bad <= parity_wrong(cfg_par, shreg, rx);
                            any_one <= any_one | rx;
                            smp_cnt <= '0;
                        end else begin
                            smp_cnt <= smp_cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (at_last) begin
                            smp_cnt <= '0;
                            if (stop_idx == cfg_two_stop) begin
                                done      <= 1'b1;
                                done_data <= shreg;
                                done_err[ERR_OVR] <= 1'b0;
                                done_err[ERR_BRK] <= ~(any_one | rx);
                                done_err[ERR_FRM] <= stop_bad | ~rx;
                                done_err[ERR_PAR] <= par_bad & (any_one | rx);
                            end else begin
                                stop_idx <= 1'b1;
                                stop_bad <= stop_bad | ~rx;
                                any_one  <= any_one | rx;
                            end
                        end else begin
                            smp_cnt <= smp_cnt + 1'b1;
                        end
                    end
                    default: smp_cnt <= '0;
                endcase
            end
        end
    end

    assert_single_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_break_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err[ERR_BRK]) |-> (done_err[ERR_FRM] && !done_err[ERR_PAR] && done_data == 8'h00));
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  rx_err_t      push_err,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output rx_err_t      head_err,
    output logic [$clog2(DEPTH):0] cnt,
    output logic         ovr_evt
);
    localparam int PW   = $clog2(DEPTH);
    localparam int CNTW = PW + 1;

    logic [W-1:0] mem_d [DEPTH];
    rx_err_t      mem_e [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic full, empty, do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CNTW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign ovr_evt = push && full && !do_pop && !clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else if (clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (!do_push && do_pop) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!clear) begin
            if (do_push) begin
                mem_d[wr_ptr] <= push_data;
                mem_e[wr_ptr] <= push_err;
            end
            if (ovr_evt) mem_e[rd_ptr][ERR_OVR] <= 1'b1;
        end
    end

    assign head_data = mem_d[rd_ptr];
    assign head_err  = mem_e[rd_ptr];

    assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clear) |=> (cnt == CNTW'(DEPTH)));

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNTW'(DEPTH));

    assert_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clear) |=> (cnt == '0));

    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
    import rxq_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int TOUT_CHARS = 4,
    parameter int CNTW       = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            tick,
    input  logic            busy,
    input  logic            frame_done,
    input  logic            err_evt,
    input  logic            pop_evt,
    input  logic [CNTW-1:0] cnt,
    input  logic [CNTW-1:0] cfg_trig,
    input  logic [1:0]      cfg_bits,
    input  logic            cfg_par_en,
    input  logic            cfg_two_stop,
    input  logic [2:0]      irq_clr,
    output logic [2:0]      status
);
    localparam int TMAX = 12 * OSR * TOUT_CHARS;
    localparam int TW   = $clog2(TMAX + 1);

    logic [TW-1:0]   timer, limit;
    logic [3:0]      char_bits;
    logic [CNTW-1:0] eff_trig;
    logic            armed, waiting, restart, tout_set, lvl_set;
    logic [2:0]      set_vec;

    assign char_bits = 4'd6 + {2'b00, cfg_bits} + {3'b000, cfg_par_en}
                     + (cfg_two_stop ? 4'd2 : 4'd1);
    assign limit     = TW'(char_bits) * TW'(OSR * TOUT_CHARS);
    assign waiting   = (cnt != '0) || armed;
    assign restart   = clear || busy || frame_done || pop_evt;
    assign tout_set  = !restart && tick && waiting && (timer == limit - 1'b1);
    assign eff_trig  = (cfg_trig == '0) ? CNTW'(1) : cfg_trig;
    assign lvl_set   = (cnt >= eff_trig);

    always_comb begin
        set_vec           = '0;
        set_vec[IRQ_LVL]  = lvl_set;
        set_vec[IRQ_ERR]  = err_evt;
        set_vec[IRQ_TOUT] = tout_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer  <= '0;
            armed  <= 1'b0;
            status <= '0;
        end else begin
            if (restart)
                timer <= '0;
            else if (tick && waiting && timer != limit)
                timer <= timer + 1'b1;

            if (clear)           armed <= 1'b0;
            else if (frame_done) armed <= 1'b1;
            else if (tout_set)   armed <= 1'b0;

            status <= set_vec | (status & ~irq_clr);
        end
    end

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr[IRQ_TOUT] && !tout_set) |=> !status[IRQ_TOUT]);

    assert_tout_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tout_set |-> !busy);
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int OSR      = 16,
    parameter int TICK_DIV = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_line,
    input  logic [1:0]               cfg_data_bits,
    input  logic [2:0]               cfg_parity,
    input  logic                     cfg_two_stop,
    input  logic                     cfg_rx_en,
    input  logic [$clog2(DEPTH):0]   cfg_trig_lvl,
    input  logic                     fifo_flush,
    input  logic                     pop_data,
    output logic [7:0]               head_data,
    output logic [3:0]               head_err,
    output logic [$clog2(DEPTH)-1:0] fifo_count,
    output logic                     fifo_full,
    input  logic [2:0]               irq_clr,
    output logic [2:0]               irq_status,
    output logic                     irq
);
    localparam int PW   = $clog2(DEPTH);
    localparam int CNTW = PW + 1;

    logic [1:0]      sync;
    logic            tick, clear, busy, done, ovr_evt;
    logic [7:0]      done_data;
    rx_err_t         done_err, head_err_w;
    logic [CNTW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rx_line};
    end

    assign clear = fifo_flush || !cfg_rx_en;

    rxq_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    rxq_deframer #(.OSR(OSR)) u_frm (
        .clk(clk), .rst_n(rst_n), .clear(clear), .tick(tick), .rx(sync[1]),
        .cfg_bits(cfg_data_bits), .cfg_par(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .done(done), .done_data(done_data), .done_err(done_err), .busy(busy)
    );

    rxq_store #(.DEPTH(DEPTH), .W(8)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .push(done), .push_data(done_data), .push_err(done_err),
        .pop(pop_data), .head_data(head_data), .head_err(head_err_w),
        .cnt(cnt), .ovr_evt(ovr_evt)
    );

    rxq_irq #(.OSR(OSR), .TOUT_CHARS(4), .CNTW(CNTW)) u_irq (
        .clk(clk), .rst_n(rst_n), .clear(clear), .tick(tick), .busy(busy),
        .frame_done(done), .err_evt((done && (|done_err)) || ovr_evt),
        .pop_evt(pop_data && (cnt != '0)), .cnt(cnt), .cfg_trig(cfg_trig_lvl),
        .cfg_bits(cfg_data_bits), .cfg_par_en(cfg_parity != PAR_NONE),
        .cfg_two_stop(cfg_two_stop), .irq_clr(irq_clr), .status(irq_status)
    );

    assign head_err   = head_err_w;
    assign fifo_count = cnt[PW-1:0];
    assign fifo_full  = cnt[PW];
    assign irq        = |irq_status;
endmodule

// File: tb/sim_uart_rx_tagged.sv
module sim_uart_rx_tagged;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_data_bits = 2'd3;
    logic [2:0] cfg_parity = 3'd0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_rx_en = 1'b1;
    logic [4:0] cfg_trig_lvl = 5'd1;
    logic       fifo_flush = 1'b0;
    logic       pop_data = 1'b0;
    logic [2:0] irq_clr = 3'b000;
    logic [7:0] head_data;
    logic [3:0] head_err;
    logic [3:0] fifo_count;
    logic       fifo_full;
    logic [2:0] irq_status;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rx_tagged #(.DEPTH(16), .OSR(16), .TICK_DIV(1)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .cfg_data_bits(cfg_data_bits), .cfg_parity(cfg_parity),
        .cfg_two_stop(cfg_two_stop), .cfg_rx_en(cfg_rx_en),
        .cfg_trig_lvl(cfg_trig_lvl), .fifo_flush(fifo_flush), .pop_data(pop_data),
        .head_data(head_data), .head_err(head_err), .fifo_count(fifo_count),
        .fifo_full(fifo_full), .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq)
    );

    // {dbits[1:0], parity[2:0], two_stop, byte[7:0], bad_par, bad_stop, exp_data[7:0], exp_err[3:0]}
    localparam logic [27:0] VEC [8] = '{
        {2'd3, 3'd0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 4'h0},
        {2'd0, 3'd0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 4'h0},
        {2'd2, 3'd1, 1'b0, 8'h53, 1'b0, 1'b0, 8'h53, 4'h0},
        {2'd3, 3'd2, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h3C, 4'h2},
        {2'd1, 3'd3, 1'b0, 8'h2A, 1'b0, 1'b0, 8'h2A, 4'h0},
        {2'd3, 3'd4, 1'b0, 8'h81, 1'b1, 1'b0, 8'h81, 4'h2},
        {2'd3, 3'd0, 1'b1, 8'h7E, 1'b0, 1'b1, 8'h7E, 4'h4},
        {2'd1, 3'd1, 1'b1, 8'h15, 1'b0, 1'b0, 8'h15, 4'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_line = b;
        wait_clks(BIT_CLKS - 1);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        int nb;
        logic p;
        nb = int'(cfg_data_bits) + 5;
        p = 1'b0;
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            send_bit(d[i]);
            p = p ^ d[i];
        end
        if (cfg_parity != 3'd0) begin
            case (cfg_parity)
                3'd1: p = p;
                3'd2: p = ~p;
                3'd3: p = 1'b1;
                default: p = 1'b0;
            endcase
            send_bit(p ^ bad_par);
        end
        send_bit(~bad_stop);
        if (cfg_two_stop) send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic pulse_pop();
        @(negedge clk); pop_data = 1'b1;
        @(negedge clk); pop_data = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); fifo_flush = 1'b1;
        @(negedge clk); fifo_flush = 1'b0;
    endtask

    task automatic clear_irqs();
        @(negedge clk); irq_clr = 3'b111;
        @(negedge clk); irq_clr = 3'b000;
    endtask

    task automatic set_8n1();
        cfg_data_bits = 2'd3; cfg_parity = 3'd0; cfg_two_stop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_clks(4);
        check("R7 reset count", 32'(fifo_count), 0);
        check("R7 reset full", 32'(fifo_full), 0);
        check("R12 reset irq", {29'd0, irq_status}, 0);
        rst_n = 1'b1;
        wait_clks(4);

        // table walk: R1 R2 R3
        for (int i = 0; i < 8; i++) begin
            logic [27:0] v;
            v = VEC[i];
            cfg_data_bits = v[27:26];
            cfg_parity    = v[25:23];
            cfg_two_stop  = v[22];
            send_frame(v[21:14], v[13], v[12]);
            wait_clks(4);
            check($sformatf("R3 vec %0d one entry", i), 32'(fifo_count), 1);
            check($sformatf("R2 R3 vec %0d err", i), 32'(head_err), 32'(v[3:0]));
            check($sformatf("R1 vec %0d data", i), 32'(head_data), 32'(v[11:4]));
            pulse_pop();
            check($sformatf("R5 vec %0d popped", i), 32'(fifo_count), 0);
        end

        // R5 pop on empty
        pulse_pop();
        wait_clks(2);
        check("R5 pop empty count", 32'(fifo_count), 0);
        check("R5 pop empty full", 32'(fifo_full), 0);

        // R4 break
        set_8n1();
        for (int i = 0; i < 12; i++) send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        check("R4 break single entry", 32'(fifo_count), 1);
        check("R4 break err", 32'(head_err), 32'h0000_000C);
        check("R4 break data", 32'(head_data), 0);
        pulse_pop();

        // R11 short glitch
        @(negedge clk); rx_line = 1'b0;
        wait_clks(5);
        rx_line = 1'b1;
        wait_clks(300);
        check("R11 glitch ignored", 32'(fifo_count), 0);

        // R6 R7 overrun
        cfg_trig_lvl = 5'd16;
        for (int i = 0; i < 17; i++) send_frame(8'(i), 1'b0, 1'b0);
        check("R7 full count wraps", 32'(fifo_count), 0);
        check("R7 full flag", 32'(fifo_full), 1);
        check("R6 overrun on head", 32'(head_err), 1);
        check("R6 head data kept", 32'(head_data), 0);
        pulse_pop();
        check("R5 count after pop", 32'(fifo_count), 15);
        check("R6 next entry clean", 32'(head_err), 0);
        check("R6 next entry data", 32'(head_data), 1);
        check("R8 error cause", 32'(irq_status[1]), 1);

        // R10 flush
        pulse_flush();
        check("R10 flush empties", 32'(fifo_count), 0);
        check("R10 flush full", 32'(fifo_full), 0);

        // R9 timeout with empty queue
        clear_irqs();
        check("R12 irq low", 32'(irq), 0);
        send_frame(8'h5A, 1'b0, 1'b0);
        pulse_pop();
        wait_clks(400);
        check("R9 no early timeout", 32'(irq_status[2]), 0);
        wait_clks(300);
        check("R9 timeout fires", 32'(irq_status[2]), 1);
        check("R9 queue empty", 32'(fifo_count), 0);
        check("R12 irq high", 32'(irq), 1);
        @(negedge clk); irq_clr = 3'b100;
        @(negedge clk); irq_clr = 3'b000;
        wait_clks(2);
        check("R8 w1c timeout", 32'(irq_status[2]), 0);
        check("R12 irq cleared", 32'(irq), 0);

        // R8 level cause
        cfg_trig_lvl = 5'd3;
        send_frame(8'h11, 1'b0, 1'b0);
        send_frame(8'h22, 1'b0, 1'b0);
        check("R8 below level", 32'(irq_status[0]), 0);
        send_frame(8'h33, 1'b0, 1'b0);
        check("R8 level reached", 32'(irq_status[0]), 1);
        clear_irqs();
        check("R8 level pending while held", 32'(irq_status[0]), 1);

        // R10 disable
        @(negedge clk); cfg_rx_en = 1'b0;
        @(negedge clk); cfg_rx_en = 1'b1;
        wait_clks(2);
        check("R10 disable empties", 32'(fifo_count), 0);

        // R10 abandon partial frame
        @(negedge clk); rx_line = 1'b0;
        wait_clks(40);
        rx_line = 1'b1;
        pulse_flush();
        wait_clks(300);
        check("R10 partial frame dropped", 32'(fifo_count), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule